// File: doc/BRIEF.md
# Multi-Sample Numerically Controlled Oscillator with Serializer

This block is a phase-accumulator oscillator whose arithmetic runs on a slow clock but yields several consecutive output samples per slow cycle. Each slow cycle it forms the phases `phase`, `phase+inc`, up to `phase+(LANES-1)*inc`. The most significant bit of each phase becomes one bit of a parallel word. The accumulator then advances by `LANES*inc`. A shift register on a fast clock, `LANES` times the slow rate and edge-aligned with it, sends that word out one bit per fast cycle. The serial stream is therefore identical to an oscillator stepping by one increment per fast clock, while no adder ever runs at the fast rate.

Typical use: feed a 32-bit frequency word on `step_i` (it may be changed at any time). Take `ser_o` as the high-rate square wave, or hand `word_o` to a dedicated output serializer instead. `LANES` selects 2, 4 or 8 samples per slow cycle.

Top module: `nco_ms_top`

## Requirements
- R1: While `rst_n` is low (synchronous, active low, held for at least two slow cycles) the accumulator, `word_o` and `ser_o` are all zero.
- R2: On each slow rising edge out of reset, the accumulator advances by `LANES*step_i` modulo 2^PHASE_W. `word_o` bit i becomes the most significant bit of (accumulator before that edge + i*step_i).
- R3: Samples are in time order within the word: bit 0 holds the earliest phase and bit LANES-1 the latest.
- R4: Counting from the first fast edge with reset released (edge 0, which coincides with a slow edge), after fast edge s+LANES-1 `ser_o` equals the most significant bit of s*inc. This matches a reference accumulator stepping one increment per fast clock, with a latency of LANES-1 fast edges.
- R5: A new `step_i` takes effect at the next slow edge without restarting the phase. The serial stream continues from the phase already reached.
- R6: `LANES` may be 2, 4 or 8, and R2 to R5 hold for each of these values.
- R7: The fast shift register loads `word_o` once per slow period, on the fast edge at which its slot counter equals LANES-1. That edge never coincides with a slow edge. On every other fast edge the register shifts toward bit 0, and `ser_o` is register bit 0.
- R8: Phase arithmetic wraps modulo 2^PHASE_W. An increment of all ones behaves as a step of minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Accumulator clock, rising edges aligned with every LANES-th fast rising edge |
| clk_fast | input | 1 | Serializer clock, LANES times the slow rate |
| rst_n | input | 1 | Synchronous active-low reset, shared by both clock domains |
| step_i | input | PHASE_W | Phase increment per output sample |
| word_o | output | LANES | Parallel samples of one slow cycle, bit 0 earliest |
| ser_o | output | 1 | Serialized sample stream, one bit per fast cycle |

## Verification
The assertions assume that the two clocks are phase-locked, with each slow rising edge landing on a fast rising edge. They also assume that reset is released just before a fast edge that is also a slow edge, so the fast slot counter starts in step with the accumulator. The bench generates both clocks from one time base and releases reset only before a fast edge whose index is a multiple of eight. That edge is a slow edge for every lane count at once. `step_i` and reset change only midway between fast edges, so every slow edge sees one settled increment. Three instances, with 2, 4 and 8 lanes, run side by side against the same stimulus.

// File: rtl/nco_ms_pkg.sv
`timescale 1ns/1ps
// Shared constants for the multi-sample oscillator.
// Assumes: phase width and lane counts are set at elaboration.
package nco_ms_pkg;
    localparam int unsigned PHASE_W_DEF = 32;
    localparam int unsigned LANES_DEF   = 4;
endpackage

// File: rtl/nco_ms_taps.sv
`timescale 1ns/1ps
// Combinational tap generator: forms base + i*step for each lane by a
// chain of adders, returns their MSBs, and the next base (base + LANES*step).
// Assumes: LANES is a power of two, so LANES*step is a plain left shift.
module nco_ms_taps #(
    parameter int unsigned PHASE_W = nco_ms_pkg::PHASE_W_DEF,
    parameter int unsigned LANES   = nco_ms_pkg::LANES_DEF
) (
    input  logic [PHASE_W-1:0] base_i,
    input  logic [PHASE_W-1:0] step_i,
    output logic [LANES-1:0]   msb_o,
    output logic [PHASE_W-1:0] next_o
);
    localparam int unsigned SH = $clog2(LANES);

    logic [PHASE_W-1:0] tap [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_tap
        if (g == 0) begin : g_first
            assign tap[g] = base_i;
        end else begin : g_rest
            assign tap[g] = tap[g-1] + step_i;
        end
        assign msb_o[g] = tap[g][PHASE_W-1];
    end

    // Next accumulator value: advance by LANES increments, modulo 2^PHASE_W.
    assign next_o = base_i + (step_i << SH);
endmodule

// File: rtl/nco_ms_phase.sv
`timescale 1ns/1ps
// Slow-domain accumulator: holds the phase and registers the parallel word
// of sample MSBs produced by the tap generator.
// Assumes: synchronous active-low reset held for at least one slow edge.
module nco_ms_phase #(
    parameter int unsigned PHASE_W = nco_ms_pkg::PHASE_W_DEF,
    parameter int unsigned LANES   = nco_ms_pkg::LANES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic [LANES-1:0]   word_o
);
    logic [LANES-1:0]   msb;
    logic [PHASE_W-1:0] next;

    nco_ms_taps #(.PHASE_W(PHASE_W), .LANES(LANES)) u_taps (
        .base_i (phase_o),
        .step_i (step_i),
        .msb_o  (msb),
        .next_o (next)
    );

    // Advance the phase and capture this cycle's samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
            word_o  <= '0;
        end else begin
            phase_o <= next;
            word_o  <= msb;
        end
    end
endmodule

// File: rtl/nco_ms_serializer.sv
`timescale 1ns/1ps
// Fast-domain serializer: a slot counter marks the position within a slow
// period; the shift register loads the parallel word at the last slot and
// shifts toward bit 0 on every other fast edge.
// Assumes: fast clock is LANES times the slow clock, edge-aligned, and reset
// is released before an edge shared by both clocks.
module nco_ms_serializer #(
    parameter int unsigned LANES = nco_ms_pkg::LANES_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] word_i,
    output logic             ser_o,
    output logic [$clog2(LANES)-1:0] slot_o
);
    localparam int unsigned SW = $clog2(LANES);
    localparam logic [SW-1:0] LAST = SW'(LANES - 1);

    logic [LANES-1:0] shreg;

    // Count fast cycles within one slow period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o <= '0;
        end else if (slot_o == LAST) begin
            slot_o <= '0;
        end else begin
            slot_o <= slot_o + 1'b1;
        end
    end

    // Load at the last slot (word is settled there), otherwise shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (slot_o == LAST) begin
            shreg <= word_i;
        end else begin
            shreg <= {1'b0, shreg[LANES-1:1]};
        end
    end

    assign ser_o = shreg[0];
endmodule

// File: rtl/nco_ms_top.sv
`timescale 1ns/1ps
// Multi-sample oscillator top: slow accumulator plus fast serializer.
// Assumes: clk_fast runs LANES times clk_slow with aligned rising edges;
// LANES is 2, 4 or 8.
module nco_ms_top #(
    parameter int unsigned PHASE_W = nco_ms_pkg::PHASE_W_DEF,
    parameter int unsigned LANES   = nco_ms_pkg::LANES_DEF
) (
    input  logic               clk_slow,
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step_i,
    output logic [LANES-1:0]   word_o,
    output logic               ser_o
);
    localparam int unsigned SW = $clog2(LANES);

    logic [PHASE_W-1:0] phase_q;
    logic [SW-1:0]      slot_q;

    nco_ms_phase #(.PHASE_W(PHASE_W), .LANES(LANES)) u_phase (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .phase_o (phase_q),
        .word_o  (word_o)
    );

    nco_ms_serializer #(.LANES(LANES)) u_ser (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .word_i (word_o),
        .ser_o  (ser_o),
        .slot_o (slot_q)
    );
endmodule

// File: rtl/nco_ms_checker.sv
`timescale 1ns/1ps
// Property checker for nco_ms_top, attached by bind.
// Assumes: aligned clocks and reset released on a shared edge.
module nco_ms_checker #(
    parameter int unsigned PHASE_W = nco_ms_pkg::PHASE_W_DEF,
    parameter int unsigned LANES   = nco_ms_pkg::LANES_DEF
) (
    input logic                     clk_slow,
    input logic                     clk_fast,
    input logic                     rst_n,
    input logic [PHASE_W-1:0]       phase_q,
    input logic [LANES-1:0]         word_o,
    input logic                     ser_o,
    input logic [$clog2(LANES)-1:0] slot_q
);
    localparam int unsigned SW = $clog2(LANES);
    localparam logic [SW-1:0] LAST = SW'(LANES - 1);

    // R1: fast side cleared by reset
    p_ser_reset_r1: assert property (@(posedge clk_fast)
        !rst_n |=> (ser_o == 1'b0 && slot_q == '0));

    // R1: slow side cleared by reset
    p_word_reset_r1: assert property (@(posedge clk_slow)
        !rst_n |=> (word_o == '0 && phase_q == '0));

    // R3: lane 0 carries the phase held before the capturing edge
    p_first_lane_r3: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $past(rst_n) |-> word_o[0] == $past(phase_q[PHASE_W-1]));

    // R7: after a load edge the serial bit is the earliest sample
    p_load_align_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ($past(rst_n) && $past(slot_q) == LAST) |-> ser_o == $past(word_o[0]));
endmodule

bind nco_ms_top nco_ms_checker #(.PHASE_W(PHASE_W), .LANES(LANES)) u_chk (
    .clk_slow (clk_slow),
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .phase_q  (phase_q),
    .word_o   (word_o),
    .ser_o    (ser_o),
    .slot_q   (slot_q)
);

// File: tb/tb_nco_ms_top.sv
`timescale 1ns/1ps
// Bench: three instances (2, 4, 8 lanes, R6) share a 50 MHz fast clock,
// reset and increment; each compares against an arithmetic model.
module tb_nco_ms_top;
    logic        clk_fast = 1'b0;
    logic        rst_n    = 1'b0;
    logic [31:0] step     = '0;
    int          abs_k    = 0;
    int          n_chk    = 0;
    int          n_err    = 0;

    task automatic chk(input bit ok, input string tag, input int nn,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (N=%0d): actual=%h expected=%h", tag, nn, act, exp);
        end
    endtask

    // 50 MHz fast clock, first rising edge at 10 ns.
    initial begin
        #10;
        forever begin
            clk_fast = 1'b1; #10;
            clk_fast = 1'b0; #10;
        end
    end

    always @(posedge clk_fast) abs_k++;

    for (genvar g = 0; g < 3; g++) begin : g_cfg
        localparam int NN = 2 << g;
        logic          clk_s = 1'b0;
        logic [NN-1:0] word;
        logic          ser;
        bit            q[$];
        logic [31:0]   mdl  = '0;
        logic [31:0]   inc_s;
        logic [31:0]   tmp;
        logic [NN-1:0] exp_w;
        bit            exp_b;
        int            k    = -1;
        int            rcnt = 0;

        // Slow clock: rises with every NN-th fast rising edge.
        initial begin
            #10;
            forever begin
                clk_s = 1'b1; #(10*NN);
                clk_s = 1'b0; #(10*NN);
            end
        end

        nco_ms_top #(.PHASE_W(32), .LANES(NN)) dut (
            .clk_slow (clk_s),
            .clk_fast (clk_fast),
            .rst_n    (rst_n),
            .step_i   (step),
            .word_o   (word),
            .ser_o    (ser)
        );

        always @(posedge clk_fast) begin
            inc_s = step;
            if (!rst_n) begin
                k = -1; rcnt++; mdl = '0; q.delete();
            end else begin
                k++; rcnt = 0;
            end
            #5;
            if (!rst_n) begin
                if (rcnt >= 2*NN)  // R1
                    chk(ser == 1'b0 && word == '0, "R1 reset", NN, 32'({ser, word}), 32'h0);
            end else begin
                if (k % NN == 0) begin
                    // R2 / R3 / R5 / R8: word = MSBs of mdl + i*inc, bit 0 earliest
                    for (int i = 0; i < NN; i++) begin
                        tmp      = mdl + 32'(i) * inc_s;
                        exp_w[i] = tmp[31];
                        q.push_back(tmp[31]);
                    end
                    mdl = mdl + 32'(NN) * inc_s;
                    chk(word == exp_w, "R2/R3 word", NN, 32'(word), 32'(exp_w));
                end
                if (k >= NN - 1) begin
                    // R4 / R7: serial stream = one-increment-per-fast-clock reference
                    exp_b = q.pop_front();
                    chk(ser == exp_b, "R4/R7 serial", NN, 32'(ser), 32'(exp_b));
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk_fast);
        #10;
    endtask

    // Release reset just before an edge shared by every slow clock.
    task automatic release_rst();
        do begin
            @(posedge clk_fast);
            #10;
        end while (abs_k % 8 != 0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        step  = 32'h8000_0000;
        run(24);
        release_rst();
        run(64);                        // R4: half-rate toggle pattern
        step = 32'h1234_5679; run(200); // R5: change without reset
        step = 32'hFFFF_FFFF; run(100); // R8: wrap, step of minus one
        step = 32'h0000_0001; run(40);
        step = 32'h0000_0000; run(40);
        rst_n = 1'b0;                   // R1: mid-run reset
        step  = 32'h3C3C_0F01;
        run(24);
        release_rst();
        run(200);
        step = 32'h7FFF_FFFF; run(100); // R8
        for (int j = 0; j < 16; j++) begin // R5 / R6 sweep of increments
            step = (32'(j) << 28) | 32'(j * 3 + 1);
            run(24);
        end
        summary();
        $finish;
    end
endmodule